// File: doc/BRIEF.md
# Two-Digit Decimal Counter with Selectable Tens Cascade

This block counts enabled clock cycles from 00 to 99 in binary-coded decimal and then wraps back to 00. It is built from two decade stages. The low stage holds the units digit. The high stage holds the tens digit. A build-time parameter chooses how the tens stage is told to advance, and both choices give the same count sequence.

In the parallel cascade, both stages run on the common clock. The tens stage takes one step on an enabled edge only while the units stage reports that it sits at 9. In the serial cascade, the tens stage is always armed and steps on the high-to-low transition of the units "at 9" flag. This transition is the rising edge of the inverted flag. It is detected inside the single clock domain by comparing a registered copy of the flag with its upcoming value, so no derived clock exists. An overall carry flags the terminal count 99. The block is used as a decimal event or cycle counter.

Top module: `bcd_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both digits become 0 on that edge. Any pending tens step from the serial edge detector is also discarded.
- R2: On each rising edge with `enable` high, the units digit goes up by one. It wraps from 9 to 0.
- R3: On each rising edge with `enable` low, both digits keep their values. This includes a pause while the units digit is 9, and no tens step occurs later because of the pause.
- R4: The tens digit changes only on the enabled edge that takes the units digit from 9 to 0. The edge from 08 gives 09, and the next enabled edge gives 10.
- R5: When the tens digit is 9 and steps, it wraps to 0. So 99 followed by an enabled edge gives 00.
- R6: `carry_out` is 1 exactly while both digits are 9, and 0 otherwise.
- R7: The parallel cascade (parameter value `CASCADE_PARALLEL`) and the serial cascade (`CASCADE_SERIAL`) produce identical digit and carry sequences for identical `rst_n`/`enable` stimulus.
- R8: Each digit output always holds a legal BCD value, 0 to 9, on the 4-bit port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by both stages |
| rst_n | input | 1 | Synchronous active-low clear of both digits and the edge register |
| enable | input | 1 | Count enable; high advances the counter by one |
| units_bcd | output | 4 | Units digit, BCD |
| tens_bcd | output | 4 | Tens digit, BCD |
| carry_out | output | 1 | High while the count is 99 |

## Verification
Two things can fall on the same edge, and both cases are provoked deliberately. First, the units rollover and the tens step coincide at every x9 to (x+1)0 boundary. At 99 the tens wrap is added to these, and the carry drops. Second, an enable pause can land exactly while the units digit is 9, which is where the serial cascade's edge register sits with its flag high. The bench drives both cascades in lockstep through hundreds of enabled and paused edges, including holds at 9 and at 99 and a clear issued mid-count. It judges each edge against an integer reference kept modulo 100.

// File: rtl/bcd_counter_pkg.sv
// Package: shared constants and the cascade selector type.
// Assumes: digits are 4-bit BCD; radix 10 per stage.
package bcd_counter_pkg;

    localparam int DIGIT_W = 4;
    localparam int RADIX   = 10;

    typedef enum logic {
        CASCADE_PARALLEL = 1'b0,
        CASCADE_SERIAL   = 1'b1
    } cascade_e;

endpackage

// File: rtl/decade_stage.sv
// Module: one modulo-RADIX digit register with step input.
// Provides its upcoming value so that a neighbour can see a
// transition before it is registered.
// Assumes: step is synchronous to clk; reset is synchronous active-low.
module decade_stage #(
    parameter int W     = 4,
    parameter int RADIX = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] digit_q,
    output logic [W-1:0] digit_next,
    output logic         at_top
);

    localparam logic [W-1:0] TOP_VAL = W'(RADIX - 1);

    // Purpose: flag the last value of the digit's range.
    always_comb begin
        at_top = (digit_q == TOP_VAL);
    end

    // Purpose: compute the value this digit takes on the next edge.
    always_comb begin
        if (!step) begin
            digit_next = digit_q;
        end else if (at_top) begin
            digit_next = '0;
        end else begin
            digit_next = digit_q + W'(1);
        end
    end

    // Purpose: hold the digit, clearing it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_q <= '0;
        end else begin
            digit_q <= digit_next;
        end
    end

endmodule

// File: rtl/carry_fall_detect.sv
// Module: registers the units "at top" flag and raises a strobe on the
// edge where that flag goes from 1 to 0 (the rising edge of its inverse).
// Compares the registered flag with the flag's upcoming value, so the
// strobe is valid in the same cycle as the edge that clears the flag.
// Assumes: flag_next is the value flag takes after the coming edge.
module carry_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_next,
    output logic fall_strobe
);

    logic flag_q;

    // Purpose: keep the flag as it stands during the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_next;
        end
    end

    // Purpose: high-to-low transition at the coming edge.
    always_comb begin
        fall_strobe = flag_q & ~flag_next;
    end

endmodule

// File: rtl/bcd_counter.sv
// Module: two-digit BCD counter, 00..99, with a build-time choice of
// how the tens stage is advanced (shared-clock enable, or falling edge
// of the units carry detected synchronously).
// Assumes: single clock domain; synchronous active-low reset.
module bcd_counter
    import bcd_counter_pkg::*;
#(
    parameter cascade_e CASCADE = CASCADE_PARALLEL
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    output logic [DIGIT_W-1:0] units_bcd,
    output logic [DIGIT_W-1:0] tens_bcd,
    output logic               carry_out
);

    localparam logic [DIGIT_W-1:0] DIGIT_MAX = DIGIT_W'(RADIX - 1);

    logic               units_top;
    logic               tens_top;
    logic               tens_step;
    logic [DIGIT_W-1:0] units_next;
    logic [DIGIT_W-1:0] tens_next;

    decade_stage #(.W(DIGIT_W), .RADIX(RADIX)) u_units (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (enable),
        .digit_q    (units_bcd),
        .digit_next (units_next),
        .at_top     (units_top)
    );

    generate
        if (CASCADE == CASCADE_SERIAL) begin : g_serial
            logic units_top_next;
            // Purpose: upcoming value of the units carry.
            always_comb begin
                units_top_next = (units_next == DIGIT_MAX);
            end
            carry_fall_detect u_fall (
                .clk         (clk),
                .rst_n       (rst_n),
                .flag_next   (units_top_next),
                .fall_strobe (tens_step)
            );
        end else begin : g_parallel
            // Purpose: tens counts only while the units carry is high.
            always_comb begin
                tens_step = enable & units_top;
            end
        end
    endgenerate

    decade_stage #(.W(DIGIT_W), .RADIX(RADIX)) u_tens (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (tens_step),
        .digit_q    (tens_bcd),
        .digit_next (tens_next),
        .at_top     (tens_top)
    );

    // Purpose: terminal-count flag at 99.
    always_comb begin
        carry_out = units_top & tens_top;
    end

endmodule

// File: rtl/bcd_counter_checker.sv
// Module: temporal checks on the counter ports, bound into every
// instance of bcd_counter.
module bcd_counter_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [3:0] units_bcd,
    input logic [3:0] tens_bcd,
    input logic       carry_out
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (units_bcd == 4'd0 && tens_bcd == 4'd0)); // R1

    AST_UNITS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> units_bcd == (($past(units_bcd) == 4'd9) ? 4'd0 : $past(units_bcd) + 4'd1)); // R2

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(units_bcd) && $stable(tens_bcd))); // R3

    AST_TENS_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && units_bcd != 4'd9) |=> $stable(tens_bcd)); // R4

    AST_TENS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && units_bcd == 4'd9) |=> tens_bcd == (($past(tens_bcd) == 4'd9) ? 4'd0 : $past(tens_bcd) + 4'd1)); // R5

    AST_CARRY_THEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_out && enable) |=> (units_bcd == 4'd0 && tens_bcd == 4'd0 && !carry_out)); // R6

    AST_BCD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (units_bcd <= 4'd9 && tens_bcd <= 4'd9)); // R8

endmodule

bind bcd_counter bcd_counter_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .units_bcd (units_bcd),
    .tens_bcd  (tens_bcd),
    .carry_out (carry_out)
);

// File: tb/bcd_counter_tb.sv
module bcd_counter_tb;
    import bcd_counter_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [3:0] par_units, par_tens, ser_units, ser_tens;
    logic       par_carry, ser_carry;

    int vectors = 0;
    int fails   = 0;
    int ref_count = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_counter #(.CASCADE(CASCADE_PARALLEL)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .units_bcd(par_units), .tens_bcd(par_tens), .carry_out(par_carry));

    bcd_counter #(.CASCADE(CASCADE_SERIAL)) u_dut_serial (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .units_bcd(ser_units), .tens_bcd(ser_tens), .carry_out(ser_carry));

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (ref %0d)", tag, act, exp, ref_count);
        end
    endtask

    // Compare both instances against the reference at a falling edge.
    task automatic check_all(input string tag);
        check({tag, " parallel count"}, int'(par_tens) * 10 + int'(par_units), ref_count);
        check({tag, " serial count"},   int'(ser_tens) * 10 + int'(ser_units), ref_count);
        check("R6 parallel carry", int'(par_carry), int'(ref_count == 99));
        check("R6 serial carry",   int'(ser_carry), int'(ref_count == 99));
        check("R7 modes agree", {par_tens, par_units, par_carry} == {ser_tens, ser_units, ser_carry}, 1);
        check("R8 legal digits", (par_units <= 9 && par_tens <= 9 && ser_units <= 9 && ser_tens <= 9), 1);
    endtask

    // One clock: drive at falling edge, let the rising edge act, sample at next fall.
    task automatic step(input bit en);
        string tag;
        int prior;
        prior = ref_count;
        enable = en;
        @(posedge clk);
        if (en) ref_count = (ref_count + 1) % 100;
        @(negedge clk);
        if (!en)                 tag = "R3 hold";
        else if (prior == 99)    tag = "R5 wrap 99";
        else if (prior % 10 == 9) tag = "R4 tens step";
        else                     tag = "R2 units step";
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        ref_count = 0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");
    endtask

    initial begin
        enable = 1'b0;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1 reset state");
        rst_n = 1'b1;
        // Continuous count through a full cycle and past 99 -> 00.
        for (int i = 0; i < 105; i++) step(1'b1);
        // Alternating enable pattern.
        for (int i = 0; i < 60; i++) step(i[0]);
        // Park at units 9 and pause there: no tens step on resume before wrap.
        while (ref_count % 10 != 9) step(1'b1);
        for (int i = 0; i < 4; i++) step(1'b0);
        step(1'b1);
        // Run up to 99, pause on it, then wrap.
        while (ref_count != 99) step(1'b1);
        for (int i = 0; i < 3; i++) step(1'b0);
        step(1'b1);
        // Clear issued mid-count while the units digit is 9.
        for (int i = 0; i < 29; i++) step(1'b1);
        do_reset();
        // Irregular enable pattern for the rest.
        for (int i = 0; i < 150; i++) step((i % 3) != 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule